// File: doc/BRIEF.md
# Launch Handshake Receiver

This block sits on the side of a secondary processor that is held waiting after power-up. It takes 32-bit words from an inbound mailbox one at a time. Each accepted word is sent back unchanged on an outbound echo channel. The word is also checked against a fixed six-word wake-up pattern: two zeros, a one, then a vector table base, a stack pointer and an entry address. While the pattern is in progress, the last three words are captured as launch parameters.

When the echo of the sixth word has been taken, the block raises a single-cycle start strobe. The captured entry address, stack pointer and vector table base are presented on dedicated outputs. The block then stops accepting input until it is reset. A sender that sees an echo differing from what it sent is expected to restart the pattern from the beginning. The receiver restarts its own match position in the same way.

Top module: `launch_handshake_rx`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), in_ready is 1, echo_valid is 0, start is 0 and all three parameter outputs are 0.
- R2: A word accepted on the inbound channel (in_valid and in_ready high at a clock edge) appears on echo_data with echo_valid high from the next cycle. in_ready stays low until that echo has been taken.
- R3: While echo_valid is high and echo_ready is low, echo_valid and echo_data hold steady and no inbound word is consumed.
- R4: The pattern is matched in the order 0, 0, 1, vector base, stack pointer, entry address. start goes high for exactly one cycle, in the cycle after the echo of the matching sixth word is taken.
- R5: While start is high, start_vtable, start_sp and start_entry carry the fourth, fifth and sixth words of the matched pattern.
- R6: A nonzero word that does not match its position returns matching to the first position (expecting the first 0).
- R7: A zero word that does not match its position counts as the first 0, so matching continues by expecting the second 0.
- R8: A vector base word with any of its low 7 bits set is a mismatch and, being nonzero, returns matching to the first position.
- R9: After start, in_ready and echo_valid stay 0 and further inbound words are ignored until reset.
- R10: With no inbound words, the block makes no progress and never raises start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inbound word present |
| in_ready | output | 1 | Block can accept an inbound word |
| in_data | input | 32 | Inbound word |
| echo_valid | output | 1 | Echo word present |
| echo_ready | input | 1 | Outbound side takes the echo |
| echo_data | output | 32 | Echoed copy of the accepted word |
| start | output | 1 | One-cycle launch strobe |
| start_vtable | output | 32 | Captured vector table base |
| start_sp | output | 32 | Captured stack pointer |
| start_entry | output | 32 | Captured entry address |

## Verification
The bench goes after these corner cases:

- **A zero that breaks the pattern after two zeros.** A design that discards this zero instead of counting it as the first 0 misses a pattern that follows it.
- **A vector base with a stray low bit.** A design that skips the alignment test launches with an unaligned table.
- **Outbound back-pressure held for several cycles.** A design that drops or overwrites the echo, or swallows the next inbound word, diverges from the reference model's echo stream.
- **Words offered after launch.** A design that keeps listening re-launches or echoes them.
- **Start timing.** A design that pulses start too early, or for too long, is caught by the reference model on the exact cycle.

// File: rtl/launch_pkg.sv
package launch_pkg;

    localparam int WORD_W     = 32;
    localparam int ALIGN_BITS = 7;

    typedef enum logic [2:0] {
        SLOT_ZERO_A,
        SLOT_ZERO_B,
        SLOT_ONE,
        SLOT_VTAB,
        SLOT_STACK,
        SLOT_ENTRY
    } slot_e;

    typedef enum logic [1:0] {
        FLD_NONE,
        FLD_VTAB,
        FLD_STACK,
        FLD_ENTRY
    } field_e;

    typedef struct packed {
        logic [WORD_W-1:0] vtab;
        logic [WORD_W-1:0] stack;
        logic [WORD_W-1:0] entry;
    } launch_args_t;

    // Where matching resumes after a word that broke the pattern.
    function automatic slot_e slot_after_miss(input logic word_is_zero);
        return word_is_zero ? SLOT_ZERO_B : SLOT_ZERO_A;
    endfunction

endpackage

// File: rtl/launch_word_match.sv
module launch_word_match
    import launch_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int ALIGN = ALIGN_BITS
) (
    input  slot_e          slot_i,
    input  logic [W-1:0]   word_i,
    output logic           hit_o,
    output logic           last_o,
    output slot_e          slot_next_o,
    output field_e         field_o
);
    logic is_zero;
    logic aligned;

    assign is_zero = (word_i == '0);
    assign aligned = (word_i[ALIGN-1:0] == '0);

    always_comb begin
        hit_o   = 1'b0;
        field_o = FLD_NONE;
        case (slot_i)
            SLOT_ZERO_A, SLOT_ZERO_B: hit_o = is_zero;
            SLOT_ONE:   hit_o = (word_i == W'(1));
            SLOT_VTAB:  begin hit_o = aligned; field_o = aligned ? FLD_VTAB : FLD_NONE; end
            SLOT_STACK: begin hit_o = 1'b1;    field_o = FLD_STACK; end
            SLOT_ENTRY: begin hit_o = 1'b1;    field_o = FLD_ENTRY; end
            default:    hit_o = 1'b0;
        endcase
    end

    always_comb begin
        if (!hit_o) begin
            slot_next_o = slot_after_miss(is_zero);
        end else begin
            case (slot_i)
                SLOT_ZERO_A: slot_next_o = SLOT_ZERO_B;
                SLOT_ZERO_B: slot_next_o = SLOT_ONE;
                SLOT_ONE:    slot_next_o = SLOT_VTAB;
                SLOT_VTAB:   slot_next_o = SLOT_STACK;
                SLOT_STACK:  slot_next_o = SLOT_ENTRY;
                default:     slot_next_o = SLOT_ZERO_A;
            endcase
        end
    end

    assign last_o = hit_o && (slot_i == SLOT_ENTRY);

endmodule

// File: rtl/launch_param_store.sv
module launch_param_store
    import launch_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int ALIGN = ALIGN_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  field_e        cap_field,
    input  logic [W-1:0]  word_i,
    output launch_args_t  args_o
);
    launch_args_t args_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            args_q <= '0;
        end else if (cap_en) begin
            case (cap_field)
                FLD_VTAB:  args_q.vtab  <= word_i;
                FLD_STACK: args_q.stack <= word_i;
                FLD_ENTRY: args_q.entry <= word_i;
                default:   args_q       <= args_q;
            endcase
        end
    end

    assign args_o = args_q;

    // R8
    vtab_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        args_q.vtab[ALIGN-1:0] == '0);

endmodule

// File: rtl/launch_handshake_rx.sv
module launch_handshake_rx
    import launch_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int ALIGN = ALIGN_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_data,
    output logic          echo_valid,
    input  logic          echo_ready,
    output logic [W-1:0]  echo_data,
    output logic          start,
    output logic [W-1:0]  start_vtable,
    output logic [W-1:0]  start_sp,
    output logic [W-1:0]  start_entry
);
    slot_e        slot_q;
    slot_e        slot_nx;
    field_e       cap_field;
    logic         hit;
    logic         last;
    logic         pend_q;
    logic [W-1:0] echo_q;
    logic         armed_q;
    logic         done_q;
    logic         start_q;
    logic         in_fire;
    logic         echo_fire;
    launch_args_t args;

    assign in_ready  = !pend_q && !done_q;
    assign in_fire   = in_valid && in_ready;
    assign echo_fire = pend_q && echo_ready;

    launch_word_match #(.W(W), .ALIGN(ALIGN)) u_match (
        .slot_i      (slot_q),
        .word_i      (in_data),
        .hit_o       (hit),
        .last_o      (last),
        .slot_next_o (slot_nx),
        .field_o     (cap_field)
    );

    launch_param_store #(.W(W), .ALIGN(ALIGN)) u_store (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (in_fire),
        .cap_field (cap_field),
        .word_i    (in_data),
        .args_o    (args)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q  <= SLOT_ZERO_A;
            pend_q  <= 1'b0;
            echo_q  <= '0;
            armed_q <= 1'b0;
            done_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (in_fire) begin
                pend_q  <= 1'b1;
                echo_q  <= in_data;
                slot_q  <= slot_nx;
                armed_q <= last;
            end else if (echo_fire) begin
                pend_q <= 1'b0;
                if (armed_q) begin
                    start_q <= 1'b1;
                    done_q  <= 1'b1;
                    armed_q <= 1'b0;
                end
            end
        end
    end

    assign echo_valid   = pend_q;
    assign echo_data    = echo_q;
    assign start        = start_q;
    assign start_vtable = args.vtab;
    assign start_sp     = args.stack;
    assign start_entry  = args.entry;

    // R2
    echo_copy_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> echo_valid && echo_data == $past(in_data));

    // R3
    echo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        echo_valid && !echo_ready |=> echo_valid && $stable(echo_data));

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    // R4
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> $past(echo_valid && echo_ready));

    // R8
    misalign_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready && slot_q == SLOT_VTAB && in_data[ALIGN-1:0] != '0
        |=> slot_q == SLOT_ZERO_A);

    // R9
    quiet_after_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !in_ready && !echo_valid);

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid && !echo_valid |=> $stable(slot_q) && !start);

endmodule

// File: tb/launch_handshake_rx_tb.sv
module launch_handshake_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        echo_valid;
    logic        echo_ready = 1'b1;
    logic [31:0] echo_data;
    logic        start;
    logic [31:0] start_vtable, start_sp, start_entry;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    int starts_seen = 0;
    bit backpressure = 1'b0;
    bit finished = 1'b0;

    // reference model state
    int          m_pos = 0;
    bit          m_pend = 0, m_armed = 0, m_done = 0, m_start = 0;
    logic [31:0] m_echo = '0, m_vt = '0, m_sp = '0, m_en = '0;

    always #10 clk = ~clk;

    launch_handshake_rx dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .echo_valid(echo_valid), .echo_ready(echo_ready), .echo_data(echo_data),
        .start(start), .start_vtable(start_vtable),
        .start_sp(start_sp), .start_entry(start_entry)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        bit rdy, acc, hit;
        rdy = !m_pend && !m_done;
        acc = in_valid && rdy;
        m_start = 0;
        if (rst) begin
            m_pos = 0; m_pend = 0; m_armed = 0; m_done = 0;
            m_echo = '0; m_vt = '0; m_sp = '0; m_en = '0;
        end else if (acc) begin
            m_pend = 1; m_echo = in_data;
            case (m_pos)
                0, 1: hit = (in_data == 0);
                2: hit = (in_data == 1);
                3: hit = (in_data[6:0] == 0);
                default: hit = 1;
            endcase
            if (hit && m_pos == 3) m_vt = in_data;
            if (m_pos == 4) m_sp = in_data;
            if (m_pos == 5) m_en = in_data;
            m_armed = hit && m_pos == 5;
            if (!hit) m_pos = (in_data == 0) ? 1 : 0;
            else m_pos = (m_pos == 5) ? 0 : m_pos + 1;
        end else if (m_pend && echo_ready) begin
            m_pend = 0;
            if (m_armed) begin m_start = 1; m_done = 1; m_armed = 0; end
        end
    end

    // compare every cycle away from the edge; then drive back-pressure
    always @(negedge clk) begin
        if (!finished) begin
            check(in_ready === (!m_pend && !m_done), "R2", "in_ready", 32'(in_ready), 32'(!m_pend && !m_done));
            check(echo_valid === m_pend, "R3", "echo_valid", 32'(echo_valid), 32'(m_pend));
            if (m_pend) check(echo_data === m_echo, "R2", "echo_data", echo_data, m_echo);
            check(start === m_start, "R4", "start", 32'(start), 32'(m_start));
            check(start_vtable === m_vt, "R5", "start_vtable", start_vtable, m_vt);
            check(start_sp === m_sp, "R5", "start_sp", start_sp, m_sp);
            check(start_entry === m_en, "R5", "start_entry", start_entry, m_en);
            if (start === 1'b1) starts_seen++;
        end
        echo_ready <= backpressure ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    task automatic do_reset();
        @(negedge clk); rst = 1; in_valid = 0;
        @(negedge clk); @(negedge clk); rst = 0;
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1; in_data = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic send_full(input logic [31:0] vt, input logic [31:0] sp, input logic [31:0] en);
        send(0); send(0); send(1); send(vt); send(sp); send(en);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int s0;
        do_reset();
        // R1 reset state
        check(in_ready === 1 && echo_valid === 0 && start === 0, "R1", "reset flags",
              {29'd0, in_ready, echo_valid, start}, 32'h4);
        check(start_vtable === 0 && start_sp === 0 && start_entry === 0, "R1", "reset params",
              start_vtable | start_sp | start_entry, 0);

        // R10 idle: nothing happens without input
        s0 = starts_seen; settle(20);
        check(starts_seen == s0 && in_ready === 1, "R10", "idle progress", starts_seen - s0, 0);

        // R4 R5 clean launch
        s0 = starts_seen; send_full(32'h2000_0080, 32'h2004_0000, 32'h1000_0123); settle(4);
        check(starts_seen == s0 + 1, "R4", "clean launch", starts_seen - s0, 1);
        check(start_entry === 32'h1000_0123, "R5", "entry", start_entry, 32'h1000_0123);

        // R9 ignored after launch
        @(negedge clk); in_valid = 1; in_data = 32'h0;
        settle(10); in_valid = 0;
        check(in_ready === 0 && echo_valid === 0 && starts_seen == s0 + 1, "R9", "post-launch",
              32'(starts_seen - s0), 1);

        // R6 nonzero mismatch restarts
        do_reset(); s0 = starts_seen;
        send(0); send(0); send(5); send_full(32'h0, 32'h11, 32'h22); settle(4);
        check(starts_seen == s0 + 1, "R6", "restart then launch", starts_seen - s0, 1);

        // R7 zero mismatch counts as first zero
        do_reset(); s0 = starts_seen;
        send(0); send(0); send(0); send(0); send(1); send(32'h100); send(32'h33); send(32'h44); settle(4);
        check(starts_seen == s0 + 1, "R7", "zero reuse launch", starts_seen - s0, 1);
        check(start_vtable === 32'h100, "R7", "vtable", start_vtable, 32'h100);

        // R8 misaligned vector base rejected
        do_reset(); s0 = starts_seen;
        send(0); send(0); send(1); send(32'h2000_0040); send(32'h55); send(32'h66); settle(4);
        check(starts_seen == s0, "R8", "misaligned no launch", starts_seen - s0, 0);
        check(start_vtable === 0, "R8", "vtable not captured", start_vtable, 0);
        send_full(32'h2000_0100, 32'h77, 32'h88); settle(4);
        check(starts_seen == s0 + 1, "R8", "launch after reject", starts_seen - s0, 1);

        // R3 back-pressure on the echo channel
        do_reset(); s0 = starts_seen; backpressure = 1;
        send(3); send(0); send(9); send_full(32'h80, 32'hA5A5_0000, 32'h5A5A_0001); settle(10);
        backpressure = 0; settle(2);
        check(starts_seen == s0 + 1, "R3", "stalled launch", starts_seen - s0, 1);
        check(start_sp === 32'hA5A5_0000, "R5", "sp under stall", start_sp, 32'hA5A5_0000);

        // R2 random words with stalls, model compares every cycle
        do_reset(); backpressure = 1;
        for (int i = 0; i < 200; i++) send($urandom_range(0, 3) == 0 ? 32'h0 : $urandom());
        backpressure = 0; settle(4);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule